// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a three-tap FIR filter that works on blocks of three samples at a time. On every clock where the block-valid input is high it accepts three consecutive samples on its input lanes and, one clock later, presents the three matching filtered samples on its output lanes. The sample rate it sustains is therefore three times its clock rate.

Each output lane is a full three-multiplier, two-adder sum, and each lane sees the coefficients in a rotated position against the sample window. The only state that crosses from one block to the next is the last two samples of the previous block, held in two registers. The three coefficients are plain inputs and are sampled in the same cycle as the block they apply to. Converting a serial stream to lanes and back is left to the surrounding logic.

Top module: `fir3p_top`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and all output lanes read 0. The two carried samples also reset to 0, so the first block after reset is filtered as if it were preceded by two zero samples.
- R2: Lane 0 output equals a·x(3k) + b·x(3k-1) + c·x(3k-2), where x(3k-1) and x(3k-2) are the lane 2 and lane 1 samples of the previous valid block.
- R3: Lane 1 output equals a·x(3k+1) + b·x(3k) + c·x(3k-1).
- R4: Lane 2 output equals a·x(3k+2) + b·x(3k+1) + c·x(3k).
- R5: The carried samples are updated only on clocks where valid_i is 1. Lane values presented while valid_i is 0 have no effect on any later output.
- R6: valid_o is high in exactly the clock after each clock in which valid_i was high.
- R7: When valid_i is 0, all three output lanes keep their previous values.
- R8: Lane 0 carries the oldest sample of a block and lane 2 the newest, on both the input and the output side. An impulse on input lane 0 appears as a, b, c on output lanes 0, 1, 2 of the same block.
- R9: Samples and coefficients are two's-complement signed. The outputs are full precision (DATA_W + COEF_W + 2 bits), so no sum wraps even with all operands at the most negative value.
- R10: Each block uses the coefficients present on the clock where its valid_i is high. Coefficients may change from one block to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input block valid |
| x0_i | input | DATA_W | Oldest sample of the block, index 3k |
| x1_i | input | DATA_W | Middle sample, index 3k+1 |
| x2_i | input | DATA_W | Newest sample, index 3k+2 |
| coef_a_i | input | COEF_W | Weight of the current sample |
| coef_b_i | input | COEF_W | Weight of the sample one step back |
| coef_c_i | input | COEF_W | Weight of the sample two steps back |
| valid_o | output | 1 | Output block valid |
| y0_o | output | DATA_W+COEF_W+2 | Filtered sample 3k |
| y1_o | output | DATA_W+COEF_W+2 | Filtered sample 3k+1 |
| y2_o | output | DATA_W+COEF_W+2 | Filtered sample 3k+2 |

## Verification
The hardest behaviour to reach from the ports is the carry of samples across a gap in valid. A block has to be followed by idle cycles that drive misleading lane values, and the next block has to pick up exactly the two samples from before the gap. The stimulus interleaves valid blocks with idle cycles that carry large nonzero lane values. It uses impulses on the last lane, whose echo only shows up in the next block's lanes 0 and 1. A sample-by-sample serial reference, fed only the valid blocks, supplies every expected value.

// File: rtl/fir3p_pkg.sv
package fir3p_pkg;
  localparam int LANES = 3;
  localparam int TAPS  = 3;

  // full-precision width of a TAPS-term signed sum of products
  function automatic int acc_width(input int dw, input int cw);
    return dw + cw + $clog2(TAPS);
  endfunction
endpackage

// File: rtl/fir3p_history.sv
module fir3p_history #(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic signed [DW-1:0] newest_i,
  input  logic signed [DW-1:0] second_i,
  output logic signed [DW-1:0] prev1_o,
  output logic signed [DW-1:0] prev2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev1_o <= '0;
      prev2_o <= '0;
    end else if (load_i) begin
      prev1_o <= newest_i;
      prev2_o <= second_i;
    end
  end
endmodule

// File: rtl/fir3p_mac.sv
module fir3p_mac #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 34
) (
  input  logic signed [DW-1:0] s_cur_i,
  input  logic signed [DW-1:0] s_d1_i,
  input  logic signed [DW-1:0] s_d2_i,
  input  logic signed [CW-1:0] coef_a_i,
  input  logic signed [CW-1:0] coef_b_i,
  input  logic signed [CW-1:0] coef_c_i,
  output logic signed [AW-1:0] sum_o
);
  localparam int PW = DW + CW;

  logic signed [PW-1:0] p_a, p_b, p_c;

  always_comb begin
    p_a   = s_cur_i * coef_a_i;
    p_b   = s_d1_i  * coef_b_i;
    p_c   = s_d2_i  * coef_c_i;
    sum_o = AW'(p_a) + AW'(p_b) + AW'(p_c);
  end
endmodule

// File: rtl/fir3p_top.sv
module fir3p_top
  import fir3p_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     valid_i,
  input  logic signed [DATA_W-1:0]                 x0_i,
  input  logic signed [DATA_W-1:0]                 x1_i,
  input  logic signed [DATA_W-1:0]                 x2_i,
  input  logic signed [COEF_W-1:0]                 coef_a_i,
  input  logic signed [COEF_W-1:0]                 coef_b_i,
  input  logic signed [COEF_W-1:0]                 coef_c_i,
  output logic                                     valid_o,
  output logic signed [DATA_W+COEF_W+1:0]          y0_o,
  output logic signed [DATA_W+COEF_W+1:0]          y1_o,
  output logic signed [DATA_W+COEF_W+1:0]          y2_o
);
  localparam int AW    = acc_width(DATA_W, COEF_W);
  localparam int WIN_N = LANES + TAPS - 1;

  logic signed [DATA_W-1:0] hist_d1, hist_d2;
  // win[0] is the oldest sample, win[WIN_N-1] the newest
  logic signed [DATA_W-1:0] win [WIN_N];
  logic signed [AW-1:0]     lane_sum [LANES];
  logic signed [AW-1:0]     y_q [LANES];
  logic                     valid_q;

  always_comb begin
    win[0] = hist_d2;
    win[1] = hist_d1;
    win[2] = x0_i;
    win[3] = x1_i;
    win[4] = x2_i;
  end

  fir3p_history #(.DW(DATA_W)) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (valid_i),
    .newest_i (win[WIN_N-1]),
    .second_i (win[WIN_N-2]),
    .prev1_o  (hist_d1),
    .prev2_o  (hist_d2)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    fir3p_mac #(.DW(DATA_W), .CW(COEF_W), .AW(AW)) u_mac (
      .s_cur_i  (win[j+2]),
      .s_d1_i   (win[j+1]),
      .s_d2_i   (win[j]),
      .coef_a_i (coef_a_i),
      .coef_b_i (coef_b_i),
      .coef_c_i (coef_c_i),
      .sum_o    (lane_sum[j])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      y_q[j] <= '0;
      else if (valid_i) y_q[j] <= lane_sum[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o = valid_q;
  assign y0_o    = y_q[0];
  assign y1_o    = y_q[1];
  assign y2_o    = y_q[2];
endmodule

// File: rtl/fir3p_chk.sv
module fir3p_chk #(
  parameter int DW = 16,
  parameter int AW = 34
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic signed [DW-1:0] x1_i,
  input logic signed [DW-1:0] x2_i,
  input logic                 valid_o,
  input logic signed [AW-1:0] y0_o,
  input logic signed [AW-1:0] y1_o,
  input logic signed [AW-1:0] y2_o,
  input logic signed [DW-1:0] hist_d1,
  input logic signed [DW-1:0] hist_d2
);
  a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!valid_o && y0_o == '0 && y1_o == '0 && y2_o == '0
                       && hist_d1 == '0 && hist_d2 == '0));

  a_r6_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r6_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r7_output_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(y0_o) && $stable(y1_o) && $stable(y2_o)));

  a_r5_history_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(hist_d1) && $stable(hist_d2)));

  a_r5_history_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (hist_d1 == $past(x2_i) && hist_d2 == $past(x1_i)));
endmodule

bind fir3p_top fir3p_chk #(.DW(DATA_W), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .x1_i    (x1_i),
  .x2_i    (x2_i),
  .valid_o (valid_o),
  .y0_o    (y0_o),
  .y1_o    (y1_o),
  .y2_o    (y2_o),
  .hist_d1 (hist_d1),
  .hist_d2 (hist_d2)
);

// File: tb/tb_fir3p_top.sv
`timescale 1ns/1ps
module tb_fir3p_top;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int AW = DW + CW + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [DW-1:0] x0_i = '0, x1_i = '0, x2_i = '0;
  logic signed [CW-1:0] ca = '0, cb = '0, cc = '0;
  logic valid_o;
  logic signed [AW-1:0] y0_o, y1_o, y2_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // serial reference state: last two samples of the valid stream
  longint hm1 = 0, hm2 = 0;

  always #5 clk = ~clk;

  fir3p_top #(.DATA_W(DW), .COEF_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .x0_i(x0_i), .x1_i(x1_i), .x2_i(x2_i),
    .coef_a_i(ca), .coef_b_i(cb), .coef_c_i(cc),
    .valid_o(valid_o), .y0_o(y0_o), .y1_o(y1_o), .y2_o(y2_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_step(input longint s);
    longint r;
    r = longint'(ca) * s + longint'(cb) * hm1 + longint'(cc) * hm2;
    hm2 = hm1;
    hm1 = s;
    return r;
  endfunction

  task automatic send_block(input string req, input logic signed [DW-1:0] s0,
                            input logic signed [DW-1:0] s1,
                            input logic signed [DW-1:0] s2);
    longint e0, e1, e2;
    @(negedge clk);
    x0_i = s0; x1_i = s1; x2_i = s2; valid_i = 1'b1;
    e0 = ref_step(longint'(s0));
    e1 = ref_step(longint'(s1));
    e2 = ref_step(longint'(s2));
    @(posedge clk); #1;
    chk({req, " R6 valid"}, longint'(valid_o), 1);
    chk({req, " lane0"}, longint'(y0_o), e0);
    chk({req, " lane1"}, longint'(y1_o), e1);
    chk({req, " lane2"}, longint'(y2_o), e2);
  endtask

  task automatic idle_cycles(input int n);
    longint h0, h1, h2;
    h0 = longint'(y0_o); h1 = longint'(y1_o); h2 = longint'(y2_o);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      x0_i = 16'sh7abc; x1_i = -16'sd9999; x2_i = 16'sh5555;
      @(posedge clk); #1;
      chk("R6 idle valid_o", longint'(valid_o), 0);
      chk("R7 hold lane0", longint'(y0_o), h0);
      chk("R7 hold lane2", longint'(y2_o), h2);
      chk("R7 hold lane1", longint'(y1_o), h1);
    end
  endtask

  task automatic t_reset;
    #1;
    chk("R1 valid_o in reset", longint'(valid_o), 0);
    chk("R1 y0 in reset", longint'(y0_o), 0);
    chk("R1 y2 in reset", longint'(y2_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    ca = 16'sd2; cb = 16'sd3; cc = 16'sd4;
    // zero history: lane0 sees only a*x0
    send_block("R1 first block", 16'sd10, 16'sd20, 16'sd30);
  endtask

  task automatic t_impulse;
    ca = 16'sd3; cb = 16'sd5; cc = 16'sd7;
    send_block("R2 flush", 0, 0, 0);
    send_block("R2 flush", 0, 0, 0);
    send_block("R8 impulse lane0", 16'sd1, 0, 0);
    chk("R8 y0=a", longint'(y0_o), 3);
    chk("R8 y1=b", longint'(y1_o), 5);
    chk("R8 y2=c", longint'(y2_o), 7);
    send_block("R4 impulse lane2", 0, 0, 16'sd1);
    chk("R4 y2=a", longint'(y2_o), 3);
    send_block("R3 carry", 0, 0, 0);
    chk("R2 carry y0=b", longint'(y0_o), 5);
    chk("R3 carry y1=c", longint'(y1_o), 7);
    chk("R4 carry y2=0", longint'(y2_o), 0);
  endtask

  task automatic t_gap;
    ca = -16'sd2; cb = 16'sd11; cc = 16'sd13;
    send_block("R5 before gap", 16'sd100, -16'sd200, 16'sd300);
    idle_cycles(3);
    // next block must use -200, 300 from before the gap
    send_block("R5 after gap", 0, 0, 0);
    chk("R5 y0 uses pre-gap sample", longint'(y0_o), 11 * 300 + 13 * (-200));
  endtask

  task automatic t_random;
    for (int i = 0; i < 60; i++) begin
      ca = CW'($urandom); cb = CW'($urandom); cc = CW'($urandom);  // R10
      send_block("R2 R3 R4 R10 random", DW'($urandom), DW'($urandom), DW'($urandom));
      if (i % 7 == 3) idle_cycles(1 + i % 3);
    end
  endtask

  task automatic t_extreme;
    ca = -16'sd32768; cb = -16'sd32768; cc = -16'sd32768;
    send_block("R9 extreme", -16'sd32768, -16'sd32768, -16'sd32768);
    send_block("R9 extreme", -16'sd32768, -16'sd32768, -16'sd32768);
    chk("R9 full precision", longint'(y1_o), 3 * 64'sd1073741824);
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_gap();
    t_random();
    t_extreme();
    idle_cycles(1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule